// File: doc/BRIEF.md
# Multi-Format Slave Serial Audio Port

This block is the serial edge of a stereo audio path that runs as a slave. An external master supplies a bit clock and a word-select line. The port oversamples both with its own system clock, which must be frequency-locked to them. On the receive side it deframes playback samples from one serial data line into parallel left and right words and marks each completed stereo pair with a one-cycle strobe. On the transmit side it takes parallel left and right record words and serialises them onto the output data line in the same framing.

Two configuration inputs select the framing and the word length. The framings are I2S, MSB-justified and LSB-justified, and one setting applies to both directions. I2S and MSB-justified words are up to 20 bits long. LSB-justified words are 16, 18 or 20 bits long, and their last bit sits in the final bit slot before word select changes. Words always travel MSB first. Parallel words are left-aligned on a 20-bit bus, and any unused low bits are zero.

Top module: `serial_audio_port`

## Requirements
- R1: While reset is asserted and right after it is released, `rx_left`, `rx_right`, `rx_valid` and `sdata_o` are all zero.
- R2: With `fmt_sel`=0 (I2S), the received MSB is the bit sampled on the second rising bit-clock edge after a word-select change, and the next 19 bits follow it. The word is reported when word select changes again.
- R3: With `fmt_sel`=1 (MSB-justified; code 3 acts the same way), the received MSB is the bit sampled on the first rising edge after a word-select change, and 20 bits are taken.
- R4: With `fmt_sel`=2 (LSB-justified), `len_sel` 0, 1 or 2 selects 16, 18 or 20 bits. The word is the bits of the last N rising edges before word select changes, left-aligned into 20 bits with zero fill.
- R5: A half with word select low is the left channel, and a half with word select high is the right channel. `rx_valid` pulses for one cycle when a right word completes. It comes from a sampled bit-clock rise, and `rx_left` then holds the left word that came just before. The port gives exactly one pulse per received frame.
- R6: Bits outside the selected word positions of a half do not change the received word.
- R7: In I2S and MSB-justified modes, transmitted bits take the same slot positions as received bits. `sdata_o` is updated only after a falling bit-clock edge.
- R8: In LSB-justified mode, the transmitted LSB falls in the last slot before word select changes. The half length is measured from the preceding half.
- R9: `sdata_o` is low in every slot outside the word. In LSB-justified mode the top N bits of the parallel word are sent.
- R10: `tx_left` and `tx_right` are latched together at the falling edge that starts a left half. Changes after that point do not affect the frame being sent.
- R11: `sdata_o` does not change across a rising bit-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_sel | input | 2 | Framing: 0 I2S, 1 MSB-justified, 2 LSB-justified, 3 as 1 |
| len_sel | input | 2 | LSB-justified length: 0=16, 1=18, 2/3=20 bits |
| bck_i | input | 1 | External bit clock |
| ws_i | input | 1 | External word select (low left, high right) |
| sdata_i | input | 1 | Serial playback data in |
| rx_left | output | 20 | Last received left word, left-aligned |
| rx_right | output | 20 | Last received right word, left-aligned |
| rx_valid | output | 1 | One-cycle strobe per received stereo pair |
| tx_left | input | 20 | Left record word to send |
| tx_right | input | 20 | Right record word to send |
| sdata_o | output | 1 | Serial record data out |

## Verification
The serial inputs pass two synchroniser stages, and the edge detector then registers the previous bit-clock level. As a result, `sdata_o` settles three system clocks after a falling bit-clock edge. A received word and its strobe land three clocks after the rising edge that opens the next half. The bench holds every bit-clock phase for six system clocks. It samples `sdata_o` at the end of the low phase and again late in the high phase, so the two samples bracket each rise. Received pairs are logged whenever the strobe is seen, and they are compared after a flush frame has closed the last half.

// File: rtl/sap_pkg.sv
package sap_pkg;

  localparam int SAP_WORD_W_DEF = 20;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_MSBJ = 2'd1,
    FMT_LSBJ = 2'd2,
    FMT_ALT  = 2'd3
  } sap_fmt_e;

  // Word length selected for right-justified framing
  function automatic int lsb_len_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 18;
      default: return 20;
    endcase
  endfunction

  // Index inside the word of a given slot for left-anchored framings
  function automatic int left_anchor_index(input sap_fmt_e f, input int slot);
    return (f == FMT_I2S) ? slot - 1 : slot;
  endfunction

endpackage

// File: rtl/sap_edge_sync.sv
module sap_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bck_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic bck_rise,
  output logic bck_fall,
  output logic ws_s,
  output logic sd_s
);

  logic [2:0] tap [STAGES+1];
  logic       bck_last;

  assign tap[0] = {bck_i, ws_i, sd_i};

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [2:0] stage_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= tap[g];
    end
    assign tap[g+1] = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bck_last <= 1'b0;
    else        bck_last <= tap[STAGES][2];
  end

  assign bck_rise = tap[STAGES][2] & ~bck_last;
  assign bck_fall = ~tap[STAGES][2] & bck_last;
  assign ws_s     = tap[STAGES][1];
  assign sd_s     = tap[STAGES][0];

endmodule

// File: rtl/sap_rx_deframer.sv
module sap_rx_deframer
  import sap_pkg::*;
#(
  parameter int WORD_W = SAP_WORD_W_DEF,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              ws,
  input  logic              sd,
  input  sap_fmt_e          fmt,
  input  logic [1:0]        len_code,
  output logic [WORD_W-1:0] rx_left,
  output logic [WORD_W-1:0] rx_right,
  output logic              rx_valid
);

  localparam logic [CNT_W-1:0] POS_MAX = '1;

  logic              synced, ws_prev;
  logic [CNT_W-1:0]  pos, pos_nxt;
  logic [WORD_W-1:0] acc, acc_nxt, shreg, done_word;
  logic              new_half;

  function automatic logic [WORD_W-1:0] right_align_to_left(
    input logic [WORD_W-1:0] s, input int n);
    if (n >= WORD_W) return s;
    return s << (WORD_W - n);
  endfunction

  always_comb begin
    int k;
    new_half = !synced || (ws != ws_prev);
    if (new_half)            pos_nxt = '0;
    else if (pos != POS_MAX) pos_nxt = pos + 1'b1;
    else                     pos_nxt = pos;
    acc_nxt = new_half ? '0 : acc;
    k = left_anchor_index(fmt, int'(pos_nxt));
    for (int i = 0; i < WORD_W; i++) begin
      if (k >= 0 && k < WORD_W && i == WORD_W - 1 - k) acc_nxt[i] = sd;
    end
    done_word = (fmt == FMT_LSBJ) ? right_align_to_left(shreg, lsb_len_bits(len_code))
                                  : acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced   <= 1'b0;
      ws_prev  <= 1'b0;
      pos      <= '0;
      acc      <= '0;
      shreg    <= '0;
      rx_left  <= '0;
      rx_right <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (rise) begin
        synced  <= 1'b1;
        ws_prev <= ws;
        pos     <= pos_nxt;
        acc     <= acc_nxt;
        shreg   <= {shreg[WORD_W-2:0], sd};
        if (new_half && synced) begin
          if (!ws_prev) rx_left <= done_word;
          else begin
            rx_right <= done_word;
            rx_valid <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/sap_tx_framer.sv
module sap_tx_framer
  import sap_pkg::*;
#(
  parameter int WORD_W = SAP_WORD_W_DEF,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              ws,
  input  sap_fmt_e          fmt,
  input  logic [1:0]        len_code,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  output logic              sdata_o,
  output logic              tx_gap
);

  localparam logic [CNT_W-1:0] POS_MAX = '1;

  logic              synced, ws_prev;
  logic [CNT_W-1:0]  pos, pos_nxt;
  logic [CNT_W:0]    slot_len, slot_eff;
  logic [WORD_W-1:0] shadow_l, shadow_r, word;
  logic              new_half, bit_out;

  // Word index for a slot; -1 marks a slot outside the word
  function automatic int tx_index(input sap_fmt_e f, input int slot,
                                  input int half_len, input int n);
    if (f == FMT_LSBJ) begin
      if (half_len == 0) return -1;
      return slot - (half_len - n);
    end
    return left_anchor_index(f, slot);
  endfunction

  always_comb begin
    int k, wlen;
    new_half = !synced || (ws != ws_prev);
    if (new_half)            pos_nxt = '0;
    else if (pos != POS_MAX) pos_nxt = pos + 1'b1;
    else                     pos_nxt = pos;
    slot_eff = (new_half && synced) ? {1'b0, pos} + 1'b1 : slot_len;
    word     = ws ? shadow_r : (new_half ? tx_left : shadow_l);
    wlen     = (fmt == FMT_LSBJ) ? lsb_len_bits(len_code) : WORD_W;
    if (wlen > WORD_W) wlen = WORD_W;
    k        = tx_index(fmt, int'(pos_nxt), int'(slot_eff), wlen);
    tx_gap   = !(k >= 0 && k < wlen);
    bit_out  = 1'b0;
    for (int i = 0; i < WORD_W; i++) begin
      if (!tx_gap && i == WORD_W - 1 - k) bit_out = word[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced   <= 1'b0;
      ws_prev  <= 1'b0;
      pos      <= '0;
      slot_len <= '0;
      shadow_l <= '0;
      shadow_r <= '0;
      sdata_o  <= 1'b0;
    end else if (fall) begin
      synced  <= 1'b1;
      ws_prev <= ws;
      pos     <= pos_nxt;
      if (new_half && synced) slot_len <= {1'b0, pos} + 1'b1;
      if (new_half && !ws) begin
        shadow_l <= tx_left;
        shadow_r <= tx_right;
      end
      sdata_o <= bit_out;
    end
  end

endmodule

// File: rtl/serial_audio_port.sv
module serial_audio_port
  import sap_pkg::*;
#(
  parameter int WORD_W      = SAP_WORD_W_DEF,
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fmt_sel,
  input  logic [1:0]        len_sel,
  input  logic              bck_i,
  input  logic              ws_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] rx_left,
  output logic [WORD_W-1:0] rx_right,
  output logic              rx_valid,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  output logic              sdata_o
);

  sap_fmt_e fmt;
  logic     rise_evt, fall_evt, ws_s, sd_s, tx_gap;

  assign fmt = sap_fmt_e'(fmt_sel);

  sap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bck_i(bck_i), .ws_i(ws_i), .sd_i(sdata_i),
    .bck_rise(rise_evt), .bck_fall(fall_evt), .ws_s(ws_s), .sd_s(sd_s)
  );

  sap_rx_deframer #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rise(rise_evt), .ws(ws_s), .sd(sd_s),
    .fmt(fmt), .len_code(len_sel),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );

  sap_tx_framer #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .fall(fall_evt), .ws(ws_s),
    .fmt(fmt), .len_code(len_sel),
    .tx_left(tx_left), .tx_right(tx_right),
    .sdata_o(sdata_o), .tx_gap(tx_gap)
  );

endmodule

// File: rtl/sap_checker.sv
module sap_checker #(
  parameter int WORD_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        fmt_sel,
  input logic [1:0]        len_sel,
  input logic              rise_evt,
  input logic              fall_evt,
  input logic              tx_gap,
  input logic              rx_valid,
  input logic [WORD_W-1:0] rx_right,
  input logic              sdata_o
);

  localparam int PAD16 = (WORD_W > 16) ? WORD_W - 16 : 0;
  localparam logic [WORD_W-1:0] LOW_MASK16 = ~({WORD_W{1'b1}} << PAD16);

  assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_valid_from_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rise_evt));

  assert_out_moves_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_o) |-> $past(fall_evt));

  assert_gap_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fall_evt && tx_gap) |-> !sdata_o);

  assert_zero_fill16_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && $past(fmt_sel) == 2'd2 && $past(len_sel) == 2'd0)
      |-> ((rx_right & LOW_MASK16) == '0));

endmodule

bind serial_audio_port sap_checker #(.WORD_W(WORD_W)) u_sap_chk (
  .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .len_sel(len_sel),
  .rise_evt(rise_evt), .fall_evt(fall_evt), .tx_gap(tx_gap),
  .rx_valid(rx_valid), .rx_right(rx_right), .sdata_o(sdata_o)
);

// File: tb/serial_audio_port_bench.sv
module serial_audio_port_bench;

  localparam int W     = 20;
  localparam int SLOT  = 32;
  localparam int HALF  = 6;
  localparam int NFR   = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   fmt_sel = 2'd0, len_sel = 2'd0;
  logic         bck_i = 1'b0, ws_i = 1'b0, sdata_i = 1'b0;
  logic [W-1:0] rx_left, rx_right, tx_left = '0, tx_right = '0;
  logic         rx_valid, sdata_o;

  int n_chk = 0;
  int n_err = 0;

  logic [W-1:0] cap_l [8];
  logic [W-1:0] cap_r [8];
  int           cap_n = 0;

  always #4 clk = ~clk;

  serial_audio_port u_serial_audio_port (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .len_sel(len_sel),
    .bck_i(bck_i), .ws_i(ws_i), .sdata_i(sdata_i),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid),
    .tx_left(tx_left), .tx_right(tx_right), .sdata_o(sdata_o)
  );

  always @(negedge clk) begin
    if (rx_valid && cap_n < 8) begin
      cap_l[cap_n] = rx_left;
      cap_r[cap_n] = rx_right;
      cap_n++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // {in_word, bit} for slot j of a half carrying word w
  function automatic logic [1:0] slot_bit(input int fmt, input int n,
                                          input logic [W-1:0] w, input int j);
    if (fmt == 0) return (j >= 1 && j <= W) ? {1'b1, w[W - j]} : 2'b00;
    if (fmt == 2) return (j >= SLOT - n) ? {1'b1, w[W - 1 - (j - (SLOT - n))]} : 2'b00;
    return (j < W) ? {1'b1, w[W - 1 - j]} : 2'b00;
  endfunction

  function automatic logic [W-1:0] rx_expect(input int fmt, input int n,
                                             input logic [W-1:0] w);
    if (fmt == 2) return w & ({W{1'b1}} << (W - n));
    return w;
  endfunction

  task automatic do_reset(input logic [1:0] f, input logic [1:0] l);
    rst_n = 1'b0; fmt_sel = f; len_sel = l;
    bck_i = 1'b0; ws_i = 1'b0; sdata_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // One bit slot: returns output before the rise and late in the high phase
  task automatic send_bit(input logic w, input logic b,
                          output logic pre, output logic post);
    bck_i = 1'b0; ws_i = w; sdata_i = b;
    repeat (HALF) @(negedge clk);
    pre = sdata_o;
    bck_i = 1'b1;
    repeat (HALF - 1) @(negedge clk);
    post = sdata_o;
    @(negedge clk);
  endtask

  task automatic test_reset();
    do_reset(2'd1, 2'd0);
    check(rx_valid == 1'b0, "R1", "rx_valid after reset", 32'(rx_valid), 0);
    check(sdata_o == 1'b0, "R1", "sdata_o after reset", 32'(sdata_o), 0);
    check(rx_left == '0, "R1", "rx_left after reset", 32'(rx_left), 0);
    check(rx_right == '0, "R1", "rx_right after reset", 32'(rx_right), 0);
  endtask

  task automatic run_format(input int fmt, input int lcode,
                            input string rx_req, input string tx_req);
    logic [W-1:0] rl [NFR+1];
    logic [W-1:0] rr [NFR+1];
    logic [W-1:0] tl, tr;
    int n;
    int unstable;
    n = (fmt == 2) ? ((lcode == 0) ? 16 : (lcode == 1) ? 18 : 20) : W;
    do_reset(2'(fmt), 2'(lcode));
    cap_n = 0;
    unstable = 0;
    for (int f = 0; f <= NFR; f++) begin
      logic [31:0] got, expv;
      logic [1:0]  sv;
      logic        pre, post;
      rl[f] = (f == 1) ? '0 : W'($urandom());
      rr[f] = (f == 1) ? '0 : W'($urandom());
      if (f == 2) begin rl[f] = {1'b1, {(W-2){1'b0}}, 1'b1}; rr[f] = '1; end
      tl = W'($urandom()); tr = W'($urandom());
      tx_left = tl; tx_right = tr;
      @(negedge clk);
      got = '0; expv = '0;
      for (int j = 0; j < SLOT; j++) begin
        sv = slot_bit(fmt, n, rl[f], j);
        send_bit(1'b0, sv[1] ? sv[0] : 1'b1, pre, post);
        if (pre != post) unstable++;
        got[SLOT-1-j] = pre;
        sv = slot_bit(fmt, n, tl, j);
        expv[SLOT-1-j] = sv[1] & sv[0];
        if (j == SLOT/2) begin tx_left = ~tl; tx_right = ~tr; end
      end
      if (f >= 1 && f < NFR)
        check(got == expv, tx_req, $sformatf("left tx frame %0d", f), got, expv);
      got = '0; expv = '0;
      for (int j = 0; j < SLOT; j++) begin
        sv = slot_bit(fmt, n, rr[f], j);
        send_bit(1'b1, sv[1] ? sv[0] : 1'b1, pre, post);
        if (pre != post) unstable++;
        got[SLOT-1-j] = pre;
        sv = slot_bit(fmt, n, tr, j);
        expv[SLOT-1-j] = sv[1] & sv[0];
      end
      if (f >= 1 && f < NFR)
        check(got == expv, {tx_req, " R10"}, $sformatf("right tx frame %0d", f), got, expv);
    end
    repeat (4) @(negedge clk);
    check(unstable == 0, "R11", "output moved across a rise", 32'(unstable), 0);
    check(cap_n == NFR, "R5", "received pair count", 32'(cap_n), NFR);
    for (int i = 0; i < NFR && i < cap_n; i++) begin
      string req;
      req = (i == 1) ? {rx_req, " R6"} : rx_req;
      check(cap_l[i] == rx_expect(fmt, n, rl[i]), {req, " R5"},
            $sformatf("left rx frame %0d", i), cap_l[i], rx_expect(fmt, n, rl[i]));
      check(cap_r[i] == rx_expect(fmt, n, rr[i]), {req, " R5"},
            $sformatf("right rx frame %0d", i), cap_r[i], rx_expect(fmt, n, rr[i]));
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    test_reset();
    run_format(0, 0, "R2", "R7 R9");
    run_format(1, 0, "R3", "R7 R9");
    run_format(2, 0, "R4", "R8 R9");
    run_format(2, 1, "R4", "R8 R9");
    run_format(2, 2, "R4", "R8 R9");
    finish_run();
  end

endmodule